// File: doc/BRIEF.md
# TDM Backplane Timing Generator

This block owns the timing of a serial TDM backplane. As the timing master it counts a 16.384 MHz master clock and makes three bus signals from it. The first is a 4.096 MHz double-rate bit clock, together with an inverted copy. The second is a 2.048 MHz single-rate bit clock. The third is an active-low 8 kHz frame sync. It drives all of them onto the bus.

As a timing slave it releases every bus driver and follows the double-rate clock and frame sync arriving from the bus. The single-rate clock then comes from one of two places: the bus pin, or an internal divider. The internal divider is pulled back into frame phase at every frame boundary.

All clocks are modelled as levels sampled in the master-clock domain. The rest of the chip consumes the internal timing outputs (`tmX2`, `tmX1`, `tmFsyncN`) and a one-cycle frame-start strobe. These outputs look the same in both roles.

Top module: `tdm_timing_gen`

## Requirements
- R1: With `masterMode`=1, `busX2Out` repeats a pattern of 2 master-clock cycles high then 2 low. `busX2NOut` is always its inverse. `busX2Oe`, `busX1Oe` and `busFsOe` are all 1.
- R2: With `masterMode`=1, `busX1Out` changes level on every rising edge of `busX2Out`. It is high at the rising edge of `busX2Out` that falls inside the frame-sync low window.
- R3: With `masterMode`=1, `busFsyncNOut` is low for exactly 4 master-clock cycles. It falls while `busX2Out` is low, and it spans exactly one rising edge of `busX2Out`, which marks the frame boundary. There are exactly 512 rising edges of `busX2Out` from one falling edge of `busFsyncNOut` to the next.
- R4: With `masterMode`=0, `busX2Oe`, `busX1Oe` and `busFsOe` are all 0.
- R5: With `masterMode`=0, `tmX2` equals `busX2In` as it was 2 master-clock cycles earlier. `tmFsyncN` equals `busFsyncNIn` as it was 2 master-clock cycles earlier.
- R6: With `masterMode`=0 and `localX1`=0, `tmX1` equals `busX1In` as it was 2 master-clock cycles earlier.
- R7: With `masterMode`=0 and `localX1`=1, `busX1In` is ignored and `tmX1` is derived internally. The derived clock changes only in a cycle where `tmX2` rises. At that rise it is set to 1 if `tmFsyncN` is 0, and inverted otherwise, so its phase is fixed to the frame. `busX1Oe` stays 0.
- R8: `frameStart` is 1 for exactly the cycles in which `tmX2` is 1, `tmX2` was 0 in the previous cycle, and `tmFsyncN` is 0. This holds in both roles.
- R9: With `masterMode`=1, `tmX2`, `tmX1` and `tmFsyncN` equal `busX2Out`, `busX1Out` and `busFsyncNOut` in the same cycle.
- R10: While `rstN` is low with `masterMode`=0, the outputs are `tmX2`=0, `tmFsyncN`=1, `frameStart`=0 and all output enables 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 16.384 MHz master clock |
| rstN | input | 1 | Asynchronous active-low reset |
| masterMode | input | 1 | 1 = timing master, 0 = timing slave |
| localX1 | input | 1 | Slave only: 1 = derive the single-rate clock internally, 0 = take it from the bus |
| busX2In | input | 1 | Double-rate clock sampled from the bus |
| busX1In | input | 1 | Single-rate clock sampled from the bus |
| busFsyncNIn | input | 1 | Active-low frame sync sampled from the bus |
| busX2Out | output | 1 | Generated double-rate clock |
| busX2NOut | output | 1 | Inverted generated double-rate clock |
| busX2Oe | output | 1 | Drive enable for both double-rate clock outputs |
| busX1Out | output | 1 | Generated single-rate clock |
| busX1Oe | output | 1 | Drive enable for the single-rate clock pin |
| busFsyncNOut | output | 1 | Generated active-low frame sync |
| busFsOe | output | 1 | Drive enable for the frame sync pin |
| tmX2 | output | 1 | Internal double-rate timing |
| tmX1 | output | 1 | Internal single-rate timing |
| tmFsyncN | output | 1 | Internal active-low frame sync |
| frameStart | output | 1 | One-cycle strobe at the frame boundary |

## Verification
Faults in the frame counter show up in the master-mode bus signals within one frame (2048 cycles). A wrong prescaler shows up within one double-rate period. A bad wrap or sync decode changes either the count of 512 double-rate edges between syncs or the 4-cycle sync width. In slave mode, a wrong sampling depth appears as a mismatch against the 2-cycle-delayed bus inputs at the first edge. If the derived single-rate divider misses its realignment, it stays out of phase after a phase jump. That shows at the first frame boundary that follows, as a low `tmX1` at `frameStart` and as disagreement with the frame-locked phase for the rest of the frame.

// File: rtl/tdm_timing_pkg.sv
`timescale 1ns/1ps
package tdm_timing_pkg;
  // Strobes and levels passed from the control to the datapath.
  typedef struct packed {
    logic master;    // timing master role selected
    logic localX1;   // slave derives single-rate clock itself
    logic mX2;       // generated double-rate level
    logic mX1;       // generated single-rate level
    logic mFsN;      // generated frame sync level (active low)
    logic sX2;       // bus double-rate level, two samples deep
    logic sFsN;      // bus frame sync level, two samples deep
    logic x2Rise;    // bus double-rate edge seen at the first sample stage
    logic frameRise; // that edge coincides with frame sync low
  } tdm_strobe_t;
endpackage

// File: rtl/tdm_timing_ctl.sv
`timescale 1ns/1ps
module tdm_timing_ctl
  import tdm_timing_pkg::*;
#(
  parameter int X2_DIV       = 4,
  parameter int X2_PER_FRAME = 512
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        masterMode,
  input  logic        localX1,
  input  logic        busX2In,
  input  logic        busFsyncNIn,
  output tdm_strobe_t stb
);
  localparam int DIV_W      = $clog2(X2_DIV);
  localparam int FRAME_CLKS = X2_DIV * X2_PER_FRAME;
  localparam int CNT_W      = $clog2(FRAME_CLKS);
  localparam logic [CNT_W-1:0] LAST_C = CNT_W'(FRAME_CLKS - 1);
  localparam logic [CNT_W-1:0] HALF_C = CNT_W'(X2_DIV / 2);
  localparam logic [CNT_W-1:0] TAIL_C = CNT_W'(FRAME_CLKS - X2_DIV / 2);

  logic [CNT_W-1:0] frameCnt;
  logic x2Q, x2QQ, fsQ, fsQQ;

  // Free-running frame counter; position 0 is the frame boundary.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 frameCnt <= '0;
    else if (frameCnt == LAST_C) frameCnt <= '0;
    else                       frameCnt <= frameCnt + 1'b1;
  end

  // Two sample stages on the bus timing inputs.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      x2Q  <= 1'b0;
      x2QQ <= 1'b0;
      fsQ  <= 1'b1;
      fsQQ <= 1'b1;
    end else begin
      x2Q  <= busX2In;
      x2QQ <= x2Q;
      fsQ  <= busFsyncNIn;
      fsQQ <= fsQ;
    end
  end

  always_comb begin
    stb.master    = masterMode;
    stb.localX1   = localX1;
    stb.mX2       = ~frameCnt[DIV_W-1];
    stb.mX1       = ~frameCnt[DIV_W];
    stb.mFsN      = ~((frameCnt < HALF_C) || (frameCnt >= TAIL_C));
    stb.sX2       = x2QQ;
    stb.sFsN      = fsQQ;
    stb.x2Rise    = x2Q & ~x2QQ;
    stb.frameRise = x2Q & ~x2QQ & ~fsQ;
  end
endmodule

// File: rtl/tdm_timing_dp.sv
`timescale 1ns/1ps
module tdm_timing_dp
  import tdm_timing_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  tdm_strobe_t stb,
  input  logic        busX1In,
  output logic        busX2Out,
  output logic        busX2NOut,
  output logic        busX2Oe,
  output logic        busX1Out,
  output logic        busX1Oe,
  output logic        busFsyncNOut,
  output logic        busFsOe,
  output logic        tmX2,
  output logic        tmX1,
  output logic        tmFsyncN,
  output logic        frameStart
);
  logic x1Q, x1QQ, derivedX1, prevTmX2;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      x1Q       <= 1'b0;
      x1QQ      <= 1'b0;
      derivedX1 <= 1'b0;
      prevTmX2  <= 1'b0;
    end else begin
      x1Q      <= busX1In;
      x1QQ     <= x1Q;
      prevTmX2 <= tmX2;
      // Divide the bus double-rate clock by two, re-phased at each frame.
      if (stb.x2Rise) derivedX1 <= stb.frameRise ? 1'b1 : ~derivedX1;
    end
  end

  always_comb begin
    busX2Out     = stb.mX2;
    busX2NOut    = ~stb.mX2;
    busX1Out     = stb.mX1;
    busFsyncNOut = stb.mFsN;
    busX2Oe      = stb.master;
    busX1Oe      = stb.master;
    busFsOe      = stb.master;
    tmX2         = stb.master ? stb.mX2  : stb.sX2;
    tmFsyncN     = stb.master ? stb.mFsN : stb.sFsN;
    if (stb.master)       tmX1 = stb.mX1;
    else if (stb.localX1) tmX1 = derivedX1;
    else                  tmX1 = x1QQ;
    frameStart   = tmX2 & ~prevTmX2 & ~tmFsyncN;
  end
endmodule

// File: rtl/tdm_timing_gen.sv
`timescale 1ns/1ps
module tdm_timing_gen
  import tdm_timing_pkg::*;
#(
  parameter int X2_DIV       = 4,
  parameter int X2_PER_FRAME = 512
) (
  input  logic clk,
  input  logic rstN,
  input  logic masterMode,
  input  logic localX1,
  input  logic busX2In,
  input  logic busX1In,
  input  logic busFsyncNIn,
  output logic busX2Out,
  output logic busX2NOut,
  output logic busX2Oe,
  output logic busX1Out,
  output logic busX1Oe,
  output logic busFsyncNOut,
  output logic busFsOe,
  output logic tmX2,
  output logic tmX1,
  output logic tmFsyncN,
  output logic frameStart
);
  tdm_strobe_t stb;

  tdm_timing_ctl #(.X2_DIV(X2_DIV), .X2_PER_FRAME(X2_PER_FRAME)) i_ctl (
    .clk(clk), .rstN(rstN), .masterMode(masterMode), .localX1(localX1),
    .busX2In(busX2In), .busFsyncNIn(busFsyncNIn), .stb(stb)
  );

  tdm_timing_dp i_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .busX1In(busX1In),
    .busX2Out(busX2Out), .busX2NOut(busX2NOut), .busX2Oe(busX2Oe),
    .busX1Out(busX1Out), .busX1Oe(busX1Oe), .busFsyncNOut(busFsyncNOut),
    .busFsOe(busFsOe), .tmX2(tmX2), .tmX1(tmX1), .tmFsyncN(tmFsyncN),
    .frameStart(frameStart)
  );
endmodule

// File: rtl/tdm_timing_chk.sv
`timescale 1ns/1ps
module tdm_timing_chk (
  input logic clk,
  input logic rstN,
  input logic masterMode,
  input logic localX1,
  input logic busX2Out,
  input logic busFsyncNOut,
  input logic tmX2,
  input logic tmX1,
  input logic frameStart
);
  // R1
  x2_high_two_chk: assert property (@(posedge clk) disable iff (!rstN)
    (masterMode && $rose(busX2Out)) |=> busX2Out);

  // R3
  fs_fall_x2low_chk: assert property (@(posedge clk) disable iff (!rstN)
    (masterMode && $fell(busFsyncNOut)) |-> !busX2Out);

  // R7
  local_x1_edge_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!masterMode && localX1 && $stable(masterMode) && $stable(localX1) && !$stable(tmX1))
      |-> $rose(tmX2));

  // R8
  frame_pulse_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    frameStart |=> !frameStart);

  // R2 R7
  frame_x1_high_chk: assert property (@(posedge clk) disable iff (!rstN)
    (frameStart && (masterMode || localX1)) |-> tmX1);
endmodule

bind tdm_timing_gen tdm_timing_chk i_tdm_timing_chk (
  .clk(clk), .rstN(rstN), .masterMode(masterMode), .localX1(localX1),
  .busX2Out(busX2Out), .busFsyncNOut(busFsyncNOut), .tmX2(tmX2),
  .tmX1(tmX1), .frameStart(frameStart)
);

// File: tb/test_tdm_timing_gen.sv
`timescale 1ns/1ps
module test_tdm_timing_gen;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic masterMode = 1'b0;
  logic localX1 = 1'b0;
  logic busX2In = 1'b0;
  logic busX1In = 1'b0;
  logic busFsyncNIn = 1'b1;
  logic busX2Out, busX2NOut, busX2Oe, busX1Out, busX1Oe, busFsyncNOut, busFsOe;
  logic tmX2, tmX1, tmFsyncN, frameStart;

  int checks = 0;
  int errors = 0;
  int g = 700;          // bench bus generator position, 0..2047
  int gA, gB, gC;       // positions driven 1, 2 and 3 cycles ago

  always #4 clk = ~clk;

  tdm_timing_gen i_tdm_timing_gen (
    .clk(clk), .rstN(rstN), .masterMode(masterMode), .localX1(localX1),
    .busX2In(busX2In), .busX1In(busX1In), .busFsyncNIn(busFsyncNIn),
    .busX2Out(busX2Out), .busX2NOut(busX2NOut), .busX2Oe(busX2Oe),
    .busX1Out(busX1Out), .busX1Oe(busX1Oe), .busFsyncNOut(busFsyncNOut),
    .busFsOe(busFsOe), .tmX2(tmX2), .tmX1(tmX1), .tmFsyncN(tmFsyncN),
    .frameStart(frameStart)
  );

  function automatic bit genX2(int p);  return (p % 4) < 2; endfunction
  function automatic bit genX1(int p);  return (p % 8) < 4; endfunction
  function automatic bit genFsN(int p); return !(p < 2 || p >= 2046); endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  // Drive the bus from generator position g and shift the history.
  task automatic driveBus(input bit x1Mode);
    busX2In     = genX2(g);
    busFsyncNIn = genFsN(g);
    busX1In     = x1Mode ? ~genX1(g) : 1'b0;
    gC = gB; gB = gA; gA = g;
    g = (g + 1) % 2048;
  endtask

  task automatic resetTest();
    repeat (3) @(negedge clk);
    check(tmX2 == 1'b0, "R10 tmX2", tmX2, 0);
    check(tmFsyncN == 1'b1, "R10 tmFsyncN", tmFsyncN, 1);
    check(frameStart == 1'b0, "R10 frameStart", frameStart, 0);
    check({busX2Oe, busX1Oe, busFsOe} == 3'b000, "R10 oe", {busX2Oe, busX1Oe, busFsOe}, 0);
    rstN = 1'b1;
  endtask

  task automatic slaveBusTest();
    int oeErr = 0, x2Err = 0, fsErr = 0, x1Err = 0, fsPulseErr = 0, pulses = 0;
    masterMode = 1'b0; localX1 = 1'b0;
    for (int i = 0; i < 3; i++) begin @(negedge clk); driveBus(1'b1); end
    for (int i = 0; i < 4400; i++) begin
      @(negedge clk);
      if (busX2Oe || busX1Oe || busFsOe) oeErr++;
      if (tmX2 != genX2(gB)) x2Err++;
      if (tmFsyncN != genFsN(gB)) fsErr++;
      if (tmX1 != !genX1(gB)) x1Err++;
      if (frameStart != (genX2(gB) && !genX2(gC) && !genFsN(gB))) fsPulseErr++;
      if (frameStart) pulses++;
      driveBus(1'b1);
    end
    check(oeErr == 0, "R4 slave enables released", oeErr, 0);
    check(x2Err == 0, "R5 tmX2 delay", x2Err, 0);
    check(fsErr == 0, "R5 tmFsyncN delay", fsErr, 0);
    check(x1Err == 0, "R6 tmX1 from bus", x1Err, 0);
    check(fsPulseErr == 0, "R8 slave frameStart", fsPulseErr, 0);
    check(pulses == 2, "R8 slave frame count", pulses, 2);
  endtask

  task automatic slaveLocalTest();
    bit expX1 = 1'b0, valid = 1'b0, jumped = 1'b0, realigned = 1'b0;
    int modelErr = 0, toggles = 0, oeErr = 0, frames = 0, preMis = 0, postErr = 0;
    bit lastX1;
    localX1 = 1'b1;
    @(negedge clk); driveBus(1'b0);
    lastX1 = tmX1;
    for (int i = 0; i < 6200; i++) begin
      @(negedge clk);
      if (genX2(gB) && !genX2(gC)) begin
        if (!genFsN(gB)) begin
          expX1 = 1'b1; valid = 1'b1; frames++;
          if (jumped) realigned = 1'b1;
        end else expX1 = !expX1;
      end
      if (valid && tmX1 != expX1) modelErr++;
      if (tmX1 != lastX1) toggles++;
      lastX1 = tmX1;
      if (busX1Oe) oeErr++;
      if (jumped && !realigned && tmX1 != genX1(gB)) preMis++;
      if (realigned && tmX1 != genX1(gB)) postErr++;
      // Phase jump of one double-rate period in the middle of a frame.
      if (frames == 1 && !jumped && g == 1000) begin g = 1004; jumped = 1'b1; end
      driveBus(1'b0);
    end
    check(modelErr == 0, "R7 derived single-rate rule", modelErr, 0);
    check(toggles > 1000, "R7 busX1In ignored, derived clock runs", toggles, 1000);
    check(oeErr == 0, "R7 busX1Oe released", oeErr, 0);
    check(preMis > 0, "R7 out of phase after jump", preMis, 1);
    check(realigned && postErr == 0, "R7 realigned at frame", postErr, 0);
  endtask

  task automatic masterTest();
    bit pX2, pFs, pX1AtRise, haveRise = 1'b0, first = 1'b1;
    int runLen = 0, runErr = 0, invErr = 0, oeErr = 0, x1AltErr = 0, frX1Err = 0;
    int risesSince = 0, fsFalls = 0, perErr = 0, lowLen = 0, widErr = 0;
    int straddleErr = 0, winRises = 0, pulseErr = 0, tmErr = 0, pulses = 0;
    masterMode = 1'b1; localX1 = 1'b0;
    busX2In = 1'b0; busX1In = 1'b0; busFsyncNIn = 1'b1;
    repeat (4) @(negedge clk);
    for (int i = 0; i < 4200; i++) begin
      bit rise;
      @(negedge clk);
      if (busX2NOut != !busX2Out) invErr++;
      if (!(busX2Oe && busX1Oe && busFsOe)) oeErr++;
      if (tmX2 != busX2Out || tmX1 != busX1Out || tmFsyncN != busFsyncNOut) tmErr++;
      rise = !first && busX2Out && !pX2;
      if (frameStart != (rise && !busFsyncNOut)) pulseErr++;
      if (frameStart) pulses++;
      if (!first) begin
        if (busX2Out != pX2) begin
          if (runLen != 0 && runLen != 2) runErr++;
          runLen = (runLen == 0 && i < 4) ? 0 : 1;
          if (i >= 4) runLen = 1;
        end else if (runLen != 0) runLen++;
        if (rise) begin
          risesSince++;
          if (haveRise && busX1Out == pX1AtRise) x1AltErr++;
          pX1AtRise = busX1Out; haveRise = 1'b1;
          if (!busFsyncNOut) begin winRises++; if (!busX1Out) frX1Err++; end
        end
        if (!busFsyncNOut && pFs) begin
          if (busX2Out) straddleErr++;
          if (fsFalls > 0 && risesSince != 512) perErr++;
          fsFalls++; risesSince = 0; lowLen = 0; winRises = 0;
        end
        if (!busFsyncNOut) lowLen++;
        if (busFsyncNOut && !pFs && fsFalls > 0) begin
          if (lowLen != 4) widErr++;
          if (winRises != 1) straddleErr++;
        end
      end
      pX2 = busX2Out; pFs = busFsyncNOut; first = 1'b0;
    end
    check(runErr == 0, "R1 x2 high/low runs of 2", runErr, 0);
    check(invErr == 0, "R1 inverted output", invErr, 0);
    check(oeErr == 0, "R1 master enables", oeErr, 0);
    check(x1AltErr == 0, "R2 x1 changes each x2 rise", x1AltErr, 0);
    check(frX1Err == 0, "R2 x1 high at frame", frX1Err, 0);
    check(fsFalls >= 2 && perErr == 0, "R3 512 x2 edges per frame", perErr, 0);
    check(widErr == 0, "R3 sync width 4", widErr, 0);
    check(straddleErr == 0, "R3 sync straddles one edge", straddleErr, 0);
    check(pulseErr == 0 && pulses == 2, "R8 master frameStart", pulses, 2);
    check(tmErr == 0, "R9 internal timing follows master", tmErr, 0);
  endtask

  initial begin
    #(8 * 200000);
    check(1'b0, "watchdog", 0, 1);
    summary();
    $finish;
  end

  initial begin
    resetTest();
    slaveBusTest();
    slaveLocalTest();
    masterTest();
    summary();
    $finish;
  end
endmodule